// File: doc/BRIEF.md
# Double-Buffered Programmable Feedback Divider

This block divides a prescaled oscillator clock by a programmable ratio N and gives one pulse per N input cycles to a phase comparator. It is a 15-bit down counter. When the counter reaches zero it raises a terminal pulse and reloads itself from a counter-side ratio register.

The ratio reaches the block through two stages. The bus receiver may write a new value into a staging register at any cycle, with no regard to where the count stands. A write also sets a pending flag. The terminal pulse acts as the transfer strobe. If the flag is set at that strobe, the staged value is clamped to the minimum ratio and copied into the counter-side register, and the flag is cleared. The counter never reloads a value that is only partly written, and the period in progress always completes with its old ratio.

A second output runs at half the divider output frequency and is intended for test use.

Top module: `fbdiv_top`

## Requirements
- R1: While reset is held, `fb_pulse` and `fb_half` are low. The ratio after reset is 256. The first `fb_pulse` appears 255 cycles after reset is released, and later pulses come every 256 cycles until a new ratio is transferred.
- R2: With an active ratio N, `fb_pulse` is high for exactly one cycle, and successive pulses are N cycles apart.
- R3: A ratio written during a count period does not change the length of that period. It governs the period that starts right after the next pulse.
- R4: A written value below 17 becomes a ratio of 17. This includes the value 0.
- R5: The largest ratio, 32767, gives a period of 32767 cycles.
- R6: When several writes arrive before one pulse, only the last written value is transferred.
- R7: A write in the same cycle as a pulse is not transferred by that pulse. The period after that pulse keeps the old ratio, and the written value governs the period after the following pulse.
- R8: If no new write arrives, the active ratio is kept for every later period.
- R9: `fb_half` changes level in the cycle after each `fb_pulse` and holds its level at all other times, so it is low until the cycle after the first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled oscillator clock; the counter runs on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_wr | input | 1 | Write strobe from the bus receiver into the staging register |
| ratio_in | input | 15 | Unsigned division ratio, bit 14 most significant |
| fb_pulse | output | 1 | One-cycle pulse on terminal count; goes to the phase comparator |
| fb_half | output | 1 | Divider output divided by two, for test use |

## Verification
`fb_pulse` is decoded from the counter register. It is high in the cycle in which the count reads zero, so a ratio N shows as N falling-edge samples from one pulse to the next. A write asserted before a rising edge is captured at that edge. Its ratio only shows in the period that starts after the next pulse, so the bench measures two full periods for each write: the period that contains the write must still have the old length, and the one after it must have the new length. `fb_half` is registered from the pulse, so the bench reads it one falling edge after the pulse. All inputs change, and all outputs are sampled, on the falling edge.

// File: rtl/fbdiv_pkg.sv
`timescale 1ns/1ps
package fbdiv_pkg;

    // Width of the division ratio and of the down counter
    localparam int RATIO_W = 15;

    typedef logic [RATIO_W-1:0] ratio_t;

    // Two-stage ratio storage: bus side, counter side, pending flag
    typedef struct packed {
        ratio_t staged;
        ratio_t active;
        logic   pend;
    } latch_state_t;

    typedef struct packed {
        ratio_t cnt;
    } count_state_t;

    typedef struct packed {
        logic half;
    } half_state_t;

    // Raise a ratio to the floor value when it falls below it
    function automatic ratio_t floor_ratio(ratio_t value, ratio_t floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

endpackage

// File: rtl/fbdiv_ratio_latch.sv
`timescale 1ns/1ps
module fbdiv_ratio_latch
    import fbdiv_pkg::*;
#(
    parameter int MIN_RATIO   = 17,
    parameter int RESET_RATIO = 256
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  ratio_t wr_ratio,
    input  logic   xfer,
    output ratio_t load_ratio
);

    localparam ratio_t MIN_VAL   = ratio_t'(MIN_RATIO);
    localparam ratio_t RESET_VAL = ratio_t'(RESET_RATIO);

    latch_state_t s_d, s_q;
    ratio_t       staged_floor;

    always_comb begin
        staged_floor = floor_ratio(s_q.staged, MIN_VAL);
        s_d          = s_q;
        // Transfer on the strobe only when a fresh value waits
        if (xfer && s_q.pend) begin
            s_d.active = staged_floor;
            s_d.pend   = 1'b0;
        end
        // A write wins over the clearing by a transfer in the same cycle
        if (wr_en) begin
            s_d.staged = wr_ratio;
            s_d.pend   = 1'b1;
        end
        // Value the counter takes when it wraps in this cycle
        load_ratio = (xfer && s_q.pend) ? staged_floor : s_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.staged <= RESET_VAL;
            s_q.active <= RESET_VAL;
            s_q.pend   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4
    ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active >= MIN_VAL);

    // R3
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(s_q.active));

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (s_q.pend && s_q.staged == $past(wr_ratio)));

endmodule

// File: rtl/fbdiv_down_counter.sv
`timescale 1ns/1ps
module fbdiv_down_counter
    import fbdiv_pkg::*;
#(
    parameter int MIN_RATIO   = 17,
    parameter int RESET_RATIO = 256
) (
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t load_ratio,
    output logic   tc
);

    localparam ratio_t RESET_CNT = ratio_t'(RESET_RATIO - 1);
    localparam ratio_t MIN_CNT   = ratio_t'(MIN_RATIO - 1);
    localparam ratio_t ONE       = ratio_t'(1);

    count_state_t c_d, c_q;

    always_comb begin
        tc  = (c_q.cnt == '0);
        c_d = c_q;
        if (tc) begin
            c_d.cnt = load_ratio - ONE;
        end else begin
            c_d.cnt = c_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt <= RESET_CNT;
        end else begin
            c_q <= c_d;
        end
    end

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);

    // R4
    reload_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (c_q.cnt >= MIN_CNT));

endmodule

// File: rtl/fbdiv_half.sv
`timescale 1ns/1ps
module fbdiv_half
    import fbdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic half
);

    half_state_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (pulse) begin
            h_d.half = ~h_q.half;
        end
        half = h_q.half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.half <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

    // R9
    half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> (half != $past(half)));

    // R9
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> $stable(half));

endmodule

// File: rtl/fbdiv_top.sv
`timescale 1ns/1ps
module fbdiv_top
    import fbdiv_pkg::*;
#(
    parameter int MIN_RATIO   = 17,
    parameter int RESET_RATIO = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ratio_wr,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               fb_pulse,
    output logic               fb_half
);

    ratio_t load_ratio;
    logic   tc;

    fbdiv_ratio_latch #(
        .MIN_RATIO   (MIN_RATIO),
        .RESET_RATIO (RESET_RATIO)
    ) i_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ratio_wr),
        .wr_ratio   (ratio_in),
        .xfer       (tc),
        .load_ratio (load_ratio)
    );

    fbdiv_down_counter #(
        .MIN_RATIO   (MIN_RATIO),
        .RESET_RATIO (RESET_RATIO)
    ) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_ratio (load_ratio),
        .tc         (tc)
    );

    fbdiv_half i_half (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (tc),
        .half  (fb_half)
    );

    assign fb_pulse = tc;

endmodule

// File: tb/test_fbdiv_top.sv
`timescale 1ns/1ps
module test_fbdiv_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ratio_wr = 1'b0;
    logic [14:0] ratio_in = '0;
    logic        fb_pulse;
    logic        fb_half;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    // {value written, period expected after transfer}
    localparam int NVEC = 7;
    localparam int VEC [NVEC][2] = '{
        '{100, 100}, '{17, 17}, '{16, 17}, '{0, 17},
        '{1000, 1000}, '{300, 300}, '{18, 18}
    };

    fbdiv_top i_fbdiv_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_wr (ratio_wr),
        .ratio_in (ratio_in),
        .fb_pulse (fb_pulse),
        .fb_half  (fb_half)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Count falling edges up to the next pulse; optional writes at 1st and 2nd edge
    task automatic measure(input bit do_wr, input int v1, input int v2, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (do_wr && n == 1) begin
                ratio_wr = 1'b1;
                ratio_in = 15'(v1);
            end else if (do_wr && n == 2 && v2 >= 0) begin
                ratio_wr = 1'b1;
                ratio_in = 15'(v2);
            end else begin
                ratio_wr = 1'b0;
            end
        end while (!fb_pulse && n < 40000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        int n;
        int prev;
        bit h0;

        // R1: outputs under reset
        repeat (3) @(negedge clk);
        check("R1 pulse in reset", int'(fb_pulse), 0);
        check("R1 half in reset", int'(fb_half), 0);
        rst_n = 1'b1;

        // R1: first pulse and power-on ratio
        measure(0, 0, -1, n);
        check("R1 first pulse delay", n, 255);
        check("R9 half before first toggle", int'(fb_half), 0);
        measure(0, 0, -1, n);
        check("R1 power-on period", n, 256);
        check("R9 half after first pulse", int'(fb_half), 1);
        prev = 256;

        // R2 R3 R4: table of writes
        for (int i = 0; i < NVEC; i++) begin
            measure(1, VEC[i][0], -1, n);
            check("R3 period holding write", n, prev);
            measure(0, 0, -1, n);
            check("R2 R4 period after transfer", n, VEC[i][1]);
            prev = VEC[i][1];
        end

        // R6: two writes in one period, last wins
        measure(1, 40, 50, n);
        check("R6 period holding writes", n, prev);
        measure(0, 0, -1, n);
        check("R6 last write wins", n, 50);

        // R7: write in the pulse cycle itself
        ratio_wr = 1'b1;
        ratio_in = 15'd60;
        measure(0, 0, -1, n);
        check("R7 old ratio kept", n, 50);
        measure(0, 0, -1, n);
        check("R7 late write applied", n, 60);

        // R8: no write, ratio retained
        measure(0, 0, -1, n);
        check("R8 ratio retained", n, 60);
        measure(0, 0, -1, n);
        check("R8 ratio retained again", n, 60);

        // R9: toggle one cycle after a pulse
        h0 = fb_half;
        @(negedge clk);
        check("R9 half toggles", int'(fb_half), int'(!h0));
        measure(0, 0, -1, n);
        check("R9 half holds across period", int'(fb_half), int'(!h0));

        // R5: maximum ratio
        measure(1, 32767, -1, n);
        check("R5 period before max", n, 60);
        measure(0, 0, -1, n);
        check("R5 max period", n, 32767);

        summary();
    end

endmodule